// File: doc/BRIEF.md
# Bus Idle-Time Gate

This block decides when a transmitter on a single-wire, open-drain control bus may begin a new message. After a start event it measures how long the line has stayed high, in units of half a nominal data bit period, and raises a grant once the required quiet time has passed. The transmitter waits for that grant before it drives the first bit.

The required quiet time comes from a 3-bit code. A non-zero code n asks for 2n-1 half periods. Code 0 picks a protocol default from two context inputs: 3 bit periods when the previous send failed, 7 when this node sent the last message successfully, and 5 otherwise. A mode input chooses the start event. In one setting the count starts on the software start request. In the other it starts automatically when the transmit or receive engine reports the end of a message. Any low level on the line while counting sends the count back to zero.

The nominal bit period is the parameter `BIT_CYCLES`, given in clock cycles. The counter advances on a tick that a prescaler produces every `BIT_CYCLES/2` cycles.

Top module: `sft_timer`

## Requirements
- R1: After reset `busFree` is 0.
- R2: With `freeCode` = n (1..7), `busFree` rises exactly (2n-1)*BIT_CYCLES/2 clock edges after the edge that samples the start event, provided the line stays high.
- R3: With `freeCode` = 0 the wait is 6 half periods when `retryPending` is 1 (this takes priority), 14 when `lastWasMine` is 1, and 10 otherwise. Both inputs are sampled at the start event.
- R4: With `startOnEnd` = 0 only `txStartReq` is a start event. Pulses on `txDone` or `rxDone` do not change `busFree`.
- R5: With `startOnEnd` = 1, `txDone` or `rxDone` is a start event. A pulse on `txStartReq` does not change `busFree`.
- R6: A clock edge that samples `busIdle` = 0 while counting resets the count and the prescaler to zero. The full wait is then measured again from that edge.
- R7: Once raised, `busFree` stays 1 while `busIdle` stays 1 and no start event occurs. It falls on the first edge that samples `busIdle` = 0, and it does not rise again until a new start event.
- R8: An edge that samples `enable` = 0 clears `busFree` and abandons any count in progress. Re-enabling does not resume that count.
- R9: A start event while `busFree` is 1 clears `busFree` on that edge and starts a fresh count.
- R10: `freeCode` is captured at the start event. Changing it during the count does not alter the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 clears the count and the grant |
| freeCode | input | 3 | Quiet-time code; 0 selects the default |
| startOnEnd | input | 1 | 0: start on `txStartReq`; 1: start on end of message |
| txStartReq | input | 1 | Software start-of-message strobe |
| txDone | input | 1 | End-of-message strobe from the transmit engine |
| rxDone | input | 1 | End-of-message strobe from the receive engine |
| busIdle | input | 1 | 1 while the bus line is high |
| retryPending | input | 1 | Previous transmission failed (default-code context) |
| lastWasMine | input | 1 | This node sent the last message successfully (default-code context) |
| busFree | output | 1 | Grant: the bus has been quiet long enough |

## Verification
The bench checks the exact edge on which the grant rises for every non-zero code and for all three default contexts, including the case where both context inputs are set. An off-by-one in the half-period arithmetic or a wrong default priority shows up as a grant one tick early or late, or at the wrong default length.

A single-cycle low pulse is placed in the middle of a count. A design that pauses instead of restarting, or that forgets to clear the prescaler, raises the grant too early. Disabling mid-count and then re-enabling must leave the grant low, so a design that resumes a stale count is caught. Changing the code after the start must not shift the grant edge. Strobes of the inactive start mode, sent while the grant is up, must leave the grant set.

// File: rtl/sft_pkg.sv
package sft_pkg;

  // Strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic load;     // capture target, clear count and prescaler
    logic restart;  // clear count and prescaler
    logic run;      // advance prescaler (and count on tick)
  } sftStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FREE  = 2'd2
  } sftState_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sft_target.sv
// Converts the quiet-time code and context into a count of half bit periods.
module sft_target #(
  parameter int RETRY_BITS = 3,
  parameter int NEW_BITS   = 5,
  parameter int SAME_BITS  = 7,
  parameter int CNT_W      = 4
) (
  input  logic [2:0]       freeCode,
  input  logic             retryPending,
  input  logic             lastWasMine,
  output logic [CNT_W-1:0] halfTarget
);

  always_comb begin
    if (freeCode != 3'd0)
      halfTarget = CNT_W'(2 * int'(freeCode) - 1);
    else if (retryPending)
      halfTarget = CNT_W'(2 * RETRY_BITS);
    else if (lastWasMine)
      halfTarget = CNT_W'(2 * SAME_BITS);
    else
      halfTarget = CNT_W'(2 * NEW_BITS);
  end

endmodule

// File: rtl/sft_datapath.sv
// Half-period prescaler, half-period counter and captured target.
module sft_datapath
  import sft_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  sftStrobe_t       strobe,
  input  logic [CNT_W-1:0] targetIn,
  output logic             expire
);

  localparam int PRE_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(HALF_CYCLES - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] targetReg;
  logic             tick;

  assign tick   = strobe.run && (preCnt == PRE_LAST);
  assign expire = tick && ((halfCnt + CNT_W'(1)) == targetReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      halfCnt   <= '0;
      targetReg <= CNT_W'(1);
    end else if (strobe.load || strobe.restart) begin
      preCnt  <= '0;
      halfCnt <= '0;
      if (strobe.load) targetReg <= targetIn;
    end else if (strobe.run) begin
      if (tick) begin
        preCnt  <= '0;
        halfCnt <= halfCnt + CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/sft_ctrl.sv
// Control FSM: start-event selection, restart on bus activity, grant hold.
module sft_ctrl
  import sft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startOnEnd,
  input  logic       txStartReq,
  input  logic       txDone,
  input  logic       rxDone,
  input  logic       busIdle,
  input  logic       expire,
  output sftStrobe_t strobe,
  output logic       busFree
);

  sftState_t state, stateNext;
  logic      startEv;

  assign startEv = startOnEnd ? (txDone || rxDone) : txStartReq;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (!enable) begin
      stateNext      = ST_IDLE;
      strobe.restart = 1'b1;
    end else if (startEv) begin
      stateNext   = ST_COUNT;
      strobe.load = 1'b1;
    end else begin
      unique case (state)
        ST_COUNT: begin
          if (!busIdle) begin
            strobe.restart = 1'b1;
          end else begin
            strobe.run = 1'b1;
            if (expire) stateNext = ST_FREE;
          end
        end
        ST_FREE:  if (!busIdle) stateNext = ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busFree = (state == ST_FREE);

endmodule

// File: rtl/sft_timer.sv
module sft_timer
  import sft_pkg::*;
#(
  parameter int BIT_CYCLES = 800,
  parameter int RETRY_BITS = 3,
  parameter int NEW_BITS   = 5,
  parameter int SAME_BITS  = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [2:0] freeCode,
  input  logic       startOnEnd,
  input  logic       txStartReq,
  input  logic       txDone,
  input  logic       rxDone,
  input  logic       busIdle,
  input  logic       retryPending,
  input  logic       lastWasMine,
  output logic       busFree
);

  localparam int HALF_CYCLES = BIT_CYCLES / 2;
  localparam int MAX_HALF    = maxOf3(13, 2 * maxOf3(RETRY_BITS, NEW_BITS, SAME_BITS), 1);
  localparam int CNT_W       = $clog2(MAX_HALF + 1);

  sftStrobe_t       strobe;
  logic [CNT_W-1:0] halfTarget;
  logic             expire;

  sft_target #(
    .RETRY_BITS(RETRY_BITS), .NEW_BITS(NEW_BITS),
    .SAME_BITS(SAME_BITS),   .CNT_W(CNT_W)
  ) u_target (
    .freeCode(freeCode), .retryPending(retryPending),
    .lastWasMine(lastWasMine), .halfTarget(halfTarget)
  );

  sft_datapath #(.HALF_CYCLES(HALF_CYCLES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .targetIn(halfTarget), .expire(expire)
  );

  sft_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .startOnEnd(startOnEnd),
    .txStartReq(txStartReq), .txDone(txDone), .rxDone(rxDone),
    .busIdle(busIdle), .expire(expire), .strobe(strobe), .busFree(busFree)
  );

endmodule

// File: rtl/sft_timer_chk.sv
module sft_timer_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic startOnEnd,
  input logic txStartReq,
  input logic txDone,
  input logic rxDone,
  input logic busIdle,
  input logic busFree
);

  logic startEv;
  assign startEv = startOnEnd ? (txDone || rxDone) : txStartReq;

  // R8: disable clears the grant on the next edge
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busFree);

  // R9: a start event drops the grant and restarts the wait
  assert_start_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && startEv) |=> !busFree);

  // R6: the grant only rises after a cycle with the line high
  assert_rise_on_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busFree) |-> $past(busIdle));

  // R7: grant holds while the line stays high and nothing restarts it
  assert_grant_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busFree && busIdle && enable && !startEv) |=> busFree);

  // R7: line activity releases the grant
  assert_grant_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busFree && !busIdle && enable && !startEv) |=> !busFree);

endmodule

bind sft_timer sft_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .startOnEnd(startOnEnd),
  .txStartReq(txStartReq), .txDone(txDone), .rxDone(rxDone),
  .busIdle(busIdle), .busFree(busFree)
);

// File: tb/sim_sft_timer.sv
`timescale 1ns/1ps
module sim_sft_timer;

  localparam int BITC = 8;   // half period = 4 cycles
  localparam real TCLK = 5.0;

  typedef struct packed {
    logic [1:0] src;   // 0 txStartReq, 1 txDone, 2 rxDone
    logic [2:0] code;
    logic       retry;
    logic       mine;
    logic [7:0] wait8;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd0, 3'd1, 1'b0, 1'b0, 8'd4},
    '{2'd0, 3'd2, 1'b0, 1'b0, 8'd12},
    '{2'd0, 3'd4, 1'b0, 1'b0, 8'd28},
    '{2'd0, 3'd7, 1'b0, 1'b0, 8'd52},
    '{2'd0, 3'd0, 1'b1, 1'b0, 8'd24},
    '{2'd0, 3'd0, 1'b0, 1'b1, 8'd56},
    '{2'd0, 3'd0, 1'b0, 1'b0, 8'd40},
    '{2'd0, 3'd0, 1'b1, 1'b1, 8'd24},
    '{2'd1, 3'd3, 1'b0, 1'b0, 8'd20},
    '{2'd2, 3'd5, 1'b0, 1'b0, 8'd36}
  };

  logic clk = 0, rstN = 0, enable = 0, startOnEnd = 0;
  logic txStartReq = 0, txDone = 0, rxDone = 0, busIdle = 1;
  logic retryPending = 0, lastWasMine = 0;
  logic [2:0] freeCode = 3'd1;
  logic busFree;
  int nChecks = 0, nFail = 0;

  always #(TCLK/2) clk = ~clk;

  sft_timer #(.BIT_CYCLES(BITC)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .freeCode(freeCode),
    .startOnEnd(startOnEnd), .txStartReq(txStartReq), .txDone(txDone),
    .rxDone(rxDone), .busIdle(busIdle), .retryPending(retryPending),
    .lastWasMine(lastWasMine), .busFree(busFree)
  );

  task automatic check(input string req, input logic exp);
    nChecks++;
    if (busFree !== exp) begin
      nFail++;
      $display("FAIL %s: busFree=%b expected %b at %0t", req, busFree, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; strobe is sampled by the next edge (E0); returns at k=0
  task automatic pulse(input logic [1:0] src);
    case (src)
      2'd0:    txStartReq = 1;
      2'd1:    txDone = 1;
      default: rxDone = 1;
    endcase
    @(negedge clk);
    txStartReq = 0; txDone = 0; rxDone = 0;
  endtask

  initial begin
    #(TCLK * 100000);
    nFail++;
    $display("FAIL watchdog: expired, busFree=%b expected finish", busFree);
    $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    waitCyc(3);
    check("R1", 1'b0);
    rstN = 1; enable = 1;
    waitCyc(2);
    check("R1", 1'b0);

    // vector table: R2 non-zero codes, R3 defaults, R5 end-of-message starts, R9 restart
    for (int i = 0; i < 10; i++) begin
      startOnEnd   = (VEC[i].src != 2'd0);
      freeCode     = VEC[i].code;
      retryPending = VEC[i].retry;
      lastWasMine  = VEC[i].mine;
      pulse(VEC[i].src);
      retryPending = 0; lastWasMine = 0;
      check("R9", 1'b0);
      waitCyc(int'(VEC[i].wait8) - 1);
      check(VEC[i].code == 0 ? "R3" : (VEC[i].src != 0 ? "R5" : "R2"), 1'b0);
      waitCyc(1);
      check(VEC[i].code == 0 ? "R3" : (VEC[i].src != 0 ? "R5" : "R2"), 1'b1);
    end

    // R5: start request ignored when starting on end of message; grant held
    pulse(2'd0);
    check("R5", 1'b1);
    waitCyc(6);
    check("R5", 1'b1);

    // R4: end-of-message strobes ignored in start-request mode
    startOnEnd = 0;
    pulse(2'd1);
    check("R4", 1'b1);
    pulse(2'd2);
    waitCyc(6);
    check("R4", 1'b1);

    // R7: holds while idle, falls on line activity, stays low afterwards
    waitCyc(20);
    check("R7", 1'b1);
    busIdle = 0;
    waitCyc(1);
    check("R7", 1'b0);
    busIdle = 1;
    waitCyc(12);
    check("R7", 1'b0);

    // R6: one low cycle mid-count restarts the full window
    freeCode = 3'd1;
    pulse(2'd0);
    waitCyc(2);
    busIdle = 0;
    waitCyc(1);
    busIdle = 1;
    waitCyc(1);            // k=4: no restart would have granted here
    check("R6", 1'b0);
    waitCyc(2);            // k=6
    check("R6", 1'b0);
    waitCyc(1);            // k=7
    check("R6", 1'b1);

    // R8: disable drops grant within one edge
    enable = 0;
    waitCyc(1);
    check("R8", 1'b0);
    enable = 1;
    waitCyc(1);
    // R8: disable mid-count abandons it
    freeCode = 3'd2;
    pulse(2'd0);
    waitCyc(5);
    enable = 0;
    waitCyc(1);
    enable = 1;
    waitCyc(20);
    check("R8", 1'b0);

    // R10: code change after start has no effect
    freeCode = 3'd1;
    pulse(2'd0);
    freeCode = 3'd7;
    waitCyc(3);
    check("R10", 1'b0);
    waitCyc(1);
    check("R10", 1'b1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule